// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block folds a large set of peripheral interrupt lines into a small number of CPU request lines. The default sizing gives twelve groups of eight lines, which is ninety-six sources in all. Each line has a pending flag and an enable bit. Each group has an acknowledge bit. A group asserts its CPU request while it holds a line that is both pending and enabled and its acknowledge bit is clear. The block does not arbitrate between groups; the CPU decides which group to service first.

When the CPU fetches a vector for a group, the block picks the winning line at that moment. The winner is the lowest-numbered line that is pending and enabled. The block returns that line's index into a 256-entry vector table one cycle later, clears the line's flag and sets the group's acknowledge bit. If no pending line is enabled at fetch time, the block returns the index of the group's first line, as a software trap would.

Software reads and writes the flag, enable and acknowledge state through a simple register port. By writing flag bits directly, software can use unused positions as software interrupts.

Top module: `irqx_expander`

## Requirements
- R1: After reset, all flags, enables and acknowledge bits read 0, every `cpu_req` bit is 0 and `vec_valid` is 0.
- R2: A one-cycle high on `line_pulse[8*g+n]` sets flag bit n of group g. The flag reads back as 1 from the next cycle.
- R3: `cpu_req[g]` is 1 exactly when group g has a line whose flag and enable are both 1 and the group's acknowledge bit is 0.
- R4: A `fetch_req` with `fetch_grp`=g (g below the group count) gives `vec_valid`=1 on the next cycle. `vec_idx` then equals 32+8*g+n, where n is the delivered line.
- R5: The delivered line is the lowest-numbered line that is pending and enabled, using the enable values present in the fetch cycle.
- R6: If no pending line is enabled in the fetch cycle, `vec_idx` is 32+8*g, and the group's flags are left unchanged.
- R7: On delivery of line n, flag bit n is cleared and the group's acknowledge bit becomes 1. After the fetch, the group's `cpu_req` is 0.
- R8: Register select codes are 0 for flags, 1 for enables and 2 for acknowledge. A write with select 2 and data bit 0 = 1 clears the acknowledge bit. With data bit 0 = 0 the bit is left alone. A read with select 2 returns the acknowledge bit in data bit 0.
- R9: A write with select 0 replaces the group's flag byte, so software can both raise and drop flags.
- R10: A peripheral pulse on a line wins over a software clear or a fetch clear of the same flag in the same cycle. The flag stays 1.
- R11: Groups are independent. A fetch or register write for one group leaves the flags and requests of the other groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_pulse | input | 96 | Peripheral set pulses; bit 8*g+n is line n of group g |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 flags, 1 enables, 2 acknowledge |
| reg_grp | input | 4 | Group addressed by the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register and group |
| fetch_req | input | 1 | Vector fetch request from the CPU |
| fetch_grp | input | 4 | Group being fetched |
| cpu_req | output | 12 | Per-group request to the CPU |
| vec_valid | output | 1 | Vector index valid, one cycle after the fetch |
| vec_idx | output | 8 | Vector table index |

## Verification
A peripheral pulse can reach the same flag bit in the same cycle as a clear of that bit. The clear can come from a software flag write or from the automatic clear that comes with a vector fetch. The bench drives both collisions on purpose. In the first, it writes zero to a group's flag byte in the same cycle as the pulse. In the second, it fetches the only enabled pending line while that line pulses again. In both cases it then reads the flag byte, and it passes only if the pulsed bit is still set. The fetch case must also return the correct vector index.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
   typedef enum logic [1:0] {
      SEL_FLAG = 2'd0,
      SEL_EN   = 2'd1,
      SEL_ACK  = 2'd2,
      SEL_NONE = 2'd3
   } irqx_sel_e;
endpackage

// File: rtl/irqx_prio_enc.sv
module irqx_prio_enc #(
   parameter int WIDTH = 8,
   localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec_in,
   output logic             any_o,
   output logic [IW-1:0]    idx_o
);
   always_comb begin
      any_o = |vec_in;
      idx_o = '0;
      for (int i = WIDTH-1; i >= 0; i--) begin
         if (vec_in[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/irqx_group.sv
module irqx_group #(
   parameter int LINES = 8,
   localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pulse_i,
   input  logic             flag_we_i,
   input  logic             en_we_i,
   input  logic             ack_we_i,
   input  logic [LINES-1:0] wdata_i,
   input  logic             fetch_i,
   output logic [LINES-1:0] flags_o,
   output logic [LINES-1:0] en_o,
   output logic             ack_o,
   output logic             req_o,
   output logic             hit_o,
   output logic [LW-1:0]    line_o
);
   logic [LINES-1:0] flags_q, en_q, flag_nxt, eligible;
   logic             ack_q;

   assign eligible = flags_q & en_q;

   irqx_prio_enc #(.WIDTH(LINES)) u_prio (
      .vec_in (eligible),
      .any_o  (hit_o),
      .idx_o  (line_o)
   );

   always_comb begin
      flag_nxt = flag_we_i ? wdata_i : flags_q;
      if (fetch_i && hit_o) flag_nxt = flag_nxt & ~(LINES'(1) << line_o);
      flag_nxt = flag_nxt | pulse_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         en_q    <= '0;
         ack_q   <= 1'b0;
      end else begin
         flags_q <= flag_nxt;
         if (en_we_i) en_q <= wdata_i;
         if (fetch_i) ack_q <= 1'b1;
         else if (ack_we_i && wdata_i[0]) ack_q <= 1'b0;
      end
   end

   assign flags_o = flags_q;
   assign en_o    = en_q;
   assign ack_o   = ack_q;
   assign req_o   = hit_o && !ack_q;
endmodule

// File: rtl/irqx_vec_reg.sv
module irqx_vec_reg #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [VEC_W-1:0] idx_i,
   output logic             valid_o,
   output logic [VEC_W-1:0] idx_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         idx_o   <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) idx_o <= idx_i;
      end
   end
endmodule

// File: rtl/irqx_expander.sv
module irqx_expander #(
   parameter int NUM_GROUPS = 12,
   parameter int LINES      = 8,
   parameter int VEC_BASE   = 32,
   parameter int VEC_W      = 8,
   localparam int GW     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int LW     = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int NLINES = NUM_GROUPS * LINES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NLINES-1:0]     line_pulse,
   input  logic                  reg_we,
   input  logic [1:0]            reg_sel,
   input  logic [GW-1:0]         reg_grp,
   input  logic [LINES-1:0]      reg_wdata,
   output logic [LINES-1:0]      reg_rdata,
   input  logic                  fetch_req,
   input  logic [GW-1:0]         fetch_grp,
   output logic [NUM_GROUPS-1:0] cpu_req,
   output logic                  vec_valid,
   output logic [VEC_W-1:0]      vec_idx
);
   import irqx_pkg::*;

   if (VEC_BASE + NLINES > (1 << VEC_W)) begin : g_chk_vec
      $error("vector index space too small for the line count");
   end
   if (NUM_GROUPS < 1 || LINES < 1) begin : g_chk_size
      $error("group and line counts must be positive");
   end

   logic [LINES-1:0] flags [NUM_GROUPS];
   logic [LINES-1:0] ens   [NUM_GROUPS];
   logic [LW-1:0]    lines [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] acks, hits;
   irqx_sel_e sel;

   assign sel = irqx_sel_e'(reg_sel);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic reg_hit, fetch_hit;
      assign reg_hit   = reg_we && (int'(reg_grp) == g);
      assign fetch_hit = fetch_req && (int'(fetch_grp) == g);
      irqx_group #(.LINES(LINES)) u_grp (
         .clk       (clk),
         .rst_n     (rst_n),
         .pulse_i   (line_pulse[g*LINES +: LINES]),
         .flag_we_i (reg_hit && sel == SEL_FLAG),
         .en_we_i   (reg_hit && sel == SEL_EN),
         .ack_we_i  (reg_hit && sel == SEL_ACK),
         .wdata_i   (reg_wdata),
         .fetch_i   (fetch_hit),
         .flags_o   (flags[g]),
         .en_o      (ens[g]),
         .ack_o     (acks[g]),
         .req_o     (cpu_req[g]),
         .hit_o     (hits[g]),
         .line_o    (lines[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (int'(reg_grp) == g) begin
            case (sel)
               SEL_FLAG: reg_rdata = flags[g];
               SEL_EN:   reg_rdata = ens[g];
               SEL_ACK:  reg_rdata = LINES'(acks[g]);
               default:  reg_rdata = '0;
            endcase
         end
      end
   end

   logic             fetch_ok;
   logic [VEC_W-1:0] idx_nxt;

   always_comb begin
      fetch_ok = 1'b0;
      idx_nxt  = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (int'(fetch_grp) == g) begin
            fetch_ok = fetch_req;
            idx_nxt  = VEC_W'(VEC_BASE + g*LINES + (hits[g] ? int'(lines[g]) : 0));
         end
      end
   end

   irqx_vec_reg #(.VEC_W(VEC_W)) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (fetch_ok),
      .idx_i   (idx_nxt),
      .valid_o (vec_valid),
      .idx_o   (vec_idx)
   );
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
   parameter int NUM_GROUPS = 12,
   parameter int LINES      = 8,
   parameter int VEC_BASE   = 32,
   parameter int VEC_W      = 8,
   localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  fetch_req,
   input logic [GW-1:0]         fetch_grp,
   input logic [NUM_GROUPS-1:0] cpu_req,
   input logic                  vec_valid,
   input logic [VEC_W-1:0]      vec_idx
);
   AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
      $rose(rst_n) |-> (cpu_req == '0 && !vec_valid)); // R1

   AST_VALID_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid == $past(fetch_req && (int'(fetch_grp) < NUM_GROUPS))); // R4

   AST_IDX_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (int'(vec_idx) >= VEC_BASE + LINES*int'($past(fetch_grp)) &&
                     int'(vec_idx) <  VEC_BASE + LINES*(int'($past(fetch_grp)) + 1))); // R5

   AST_REQ_LOW_AFTER_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ((cpu_req >> $past(fetch_grp)) & 1) == 0); // R7
endmodule

bind irqx_expander irqx_checker #(
   .NUM_GROUPS(NUM_GROUPS), .LINES(LINES), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)
) u_irqx_checker (
   .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_grp(fetch_grp),
   .cpu_req(cpu_req), .vec_valid(vec_valid), .vec_idx(vec_idx)
);

// File: tb/irqx_expander_tb_top.sv
`timescale 1ns/1ps
module irqx_expander_tb_top;
   localparam int G = 12;
   localparam int L = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [G*L-1:0] line_pulse = '0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [3:0]    reg_grp = 4'd0;
   logic [7:0]    reg_wdata = 8'd0;
   logic [7:0]    reg_rdata;
   logic          fetch_req = 1'b0;
   logic [3:0]    fetch_grp = 4'd0;
   logic [G-1:0]  cpu_req;
   logic          vec_valid;
   logic [7:0]    vec_idx;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   bit done = 0;

   always #10 clk = ~clk;

   irqx_expander dut_i (
      .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .reg_we(reg_we),
      .reg_sel(reg_sel), .reg_grp(reg_grp), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .fetch_req(fetch_req), .fetch_grp(fetch_grp),
      .cpu_req(cpu_req), .vec_valid(vec_valid), .vec_idx(vec_idx)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // monitor: pop expected vectors as the design delivers them
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) check(1'b0, "R4 unexpected vector", int'(vec_idx), -1);
         else begin
            int e;
            e = exp_q.pop_front();
            check(int'(vec_idx) == e, "R4/R5/R6 vector index", int'(vec_idx), e);
         end
      end
   end

   task automatic wr(input int sel, input int g, input int d);
      reg_we = 1'b1; reg_sel = 2'(sel); reg_grp = 4'(g); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int sel, input int g, output int d);
      reg_sel = 2'(sel); reg_grp = 4'(g);
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic pulse(input int g, input int n);
      line_pulse[g*L+n] = 1'b1;
      @(negedge clk);
      line_pulse = '0;
   endtask

   task automatic fetch(input int g, input int exp);
      exp_q.push_back(exp);
      fetch_req = 1'b1; fetch_grp = 4'(g);
      @(negedge clk);
      fetch_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R4 watchdog expired", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int d;
      repeat (5) @(negedge clk);
      // R1 reset state
      check(cpu_req == '0, "R1 cpu_req in reset", int'(cpu_req), 0);
      check(!vec_valid, "R1 vec_valid in reset", int'(vec_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(0, 0, d); check(d == 0, "R1 flags grp0", d, 0);
      rd(1, 11, d); check(d == 0, "R1 enables grp11", d, 0);
      rd(2, 5, d); check(d == 0, "R1 ack grp5", d, 0);
      @(negedge clk);

      // R2, R3
      pulse(2, 3);
      rd(0, 2, d); check(d == 8'h08, "R2 flag set by pulse", d, 8'h08);
      check(cpu_req[2] == 1'b0, "R3 no request while disabled", int'(cpu_req[2]), 0);
      @(negedge clk);
      wr(1, 2, 8'hFF);
      check(cpu_req[2] == 1'b1, "R3 request when enabled", int'(cpu_req[2]), 1);

      // R4, R7
      fetch(2, 32+16+3);
      rd(0, 2, d); check(d == 0, "R7 flag cleared on delivery", d, 0);
      rd(2, 2, d); check(d == 1, "R7 ack set on delivery", d, 1);
      check(cpu_req[2] == 1'b0, "R7 request low after fetch", int'(cpu_req[2]), 0);
      @(negedge clk);

      // R8 acknowledge write semantics
      wr(2, 2, 0);
      rd(2, 2, d); check(d == 1, "R8 ack kept on write 0", d, 1);
      @(negedge clk);
      wr(2, 2, 1);
      rd(2, 2, d); check(d == 0, "R8 ack cleared on write 1", d, 0);
      @(negedge clk);

      // R5 priority: lines 6 and 1 of group 5 together
      line_pulse[5*L+6] = 1'b1; line_pulse[5*L+1] = 1'b1;
      @(negedge clk);
      line_pulse = '0;
      wr(1, 5, 8'hFF);
      fetch(5, 32+40+1);
      wr(2, 5, 1);
      check(cpu_req[5] == 1'b1, "R3 remaining line requests", int'(cpu_req[5]), 1);
      fetch(5, 32+40+6);
      wr(2, 5, 1);

      // R5 enables sampled at fetch time
      line_pulse[7*L+0] = 1'b1; line_pulse[7*L+2] = 1'b1;
      @(negedge clk);
      line_pulse = '0;
      wr(1, 7, 8'hFF);
      wr(1, 7, 8'h04);
      fetch(7, 32+56+2);
      rd(0, 7, d); check(d == 8'h01, "R5 disabled line stays pending", d, 1);
      @(negedge clk);
      wr(2, 7, 1);

      // R6 fallback
      wr(1, 7, 8'h00);
      fetch(7, 32+56);
      rd(0, 7, d); check(d == 8'h01, "R6 flags unchanged on fallback", d, 1);
      @(negedge clk);
      wr(2, 7, 1);

      // R9 software flags
      wr(0, 11, 8'h80);
      wr(1, 11, 8'h80);
      check(cpu_req[11] == 1'b1, "R9 software flag requests", int'(cpu_req[11]), 1);
      fetch(11, 32+88+7);
      wr(2, 11, 1);
      wr(0, 11, 8'h30);
      wr(0, 11, 8'h10);
      rd(0, 11, d); check(d == 8'h10, "R9 software flag replace", d, 8'h10);
      @(negedge clk);

      // R10 pulse vs software clear
      reg_we = 1'b1; reg_sel = 2'd0; reg_grp = 4'd1; reg_wdata = 8'h00;
      line_pulse[1*L+4] = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; line_pulse = '0;
      rd(0, 1, d); check(d == 8'h10, "R10 pulse beats software clear", d, 8'h10);
      @(negedge clk);
      wr(1, 1, 8'h10);
      // R10 pulse vs fetch clear
      exp_q.push_back(32+8+4);
      fetch_req = 1'b1; fetch_grp = 4'd1; line_pulse[1*L+4] = 1'b1;
      @(negedge clk);
      fetch_req = 1'b0; line_pulse = '0;
      rd(0, 1, d); check(d == 8'h10, "R10 pulse beats fetch clear", d, 8'h10);
      @(negedge clk);
      wr(2, 1, 1);

      // R11 group independence
      line_pulse[3*L] = 1'b1; line_pulse[4*L] = 1'b1;
      @(negedge clk);
      line_pulse = '0;
      wr(1, 3, 8'h01);
      wr(1, 4, 8'h01);
      check(cpu_req[4:3] == 2'b11, "R11 both groups request", int'(cpu_req[4:3]), 3);
      fetch(3, 32+24);
      rd(0, 4, d); check(d == 8'h01, "R11 other group flag kept", d, 1);
      check(cpu_req[4] == 1'b1, "R11 other group still requests", int'(cpu_req[4]), 1);
      @(negedge clk);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R4 all vectors delivered", exp_q.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule